// File: doc/BRIEF.md
# Watchdog Timer with Reset Routing

This block guards a system against stalled software. A down-counter, once started, must be restarted ("kicked") by a register write within a fixed number of clock ticks. If no kick arrives in time, the block declares an expiry. Each expiry can have three effects, and each has its own enable bit. It can latch a sticky status flag. It can request either a system-wide reset or a local-only reset. It can hold a board-failure output high.

Software reaches the block through one 32-bit register with a single write strobe and a combinational read path. Only bits 23 down to 16 carry meaning. These bits hold four configuration bits, the sticky status flag and two self-clearing command bits. Every other bit is ignored on write and reads as zero. The timeout length is the parameter `TIMEOUT_TICKS`. The asynchronous reset is released through a two-stage synchronizer.

Top module: `wdog_guard`

## Requirements
- R1: While reset is asserted and after it is released, `reg_rdata` reads 32'h0002_0000 (only the reset-arm bit set), and all three request outputs are low.
- R2: Bit 16 (RUN) enables counting. While RUN is 0, no expiry is ever recorded, however long the block waits.
- R3: Suppose a write sets RUN from 0 to 1 at clock edge E. The expiry status bit 20 then reads 1 after edge E+TIMEOUT_TICKS, and it still reads 0 after edge E+TIMEOUT_TICKS-1.
- R4: Writing 1 to bit 21 (KICK) at edge K reloads the full period, so expiry follows edge K+TIMEOUT_TICKS. A kick that lands on the same edge as a would-be expiry wins, and no expiry is recorded at that edge.
- R5: Bit 20 (EXPIRED) is sticky. Writes to bit 20 have no effect on it. It is cleared only by a write with bit 22 (ACK) set. If an expiry and an ACK fall on the same edge, the expiry wins.
- R6: Bits 21, 22 and 23 always read 0. Bits outside 23:16 always read 0. Bits 16 to 19 read back the value last written.
- R7: An expiry raises `loc_rst_req` for exactly one cycle when bit 17 (ARM) is 1. It raises `sys_rst_req` in that same cycle when ARM is 1 and bit 18 (SYSSEL) is 1. With ARM 0, neither output is raised. `sys_rst_req` never rises without `loc_rst_req`.
- R8: `board_fail` is high exactly while EXPIRED and bit 19 (FAILEN) are both 1.
- R9: After an expiry the counter rests at zero. No further expiry or reset request occurs until the counter is reloaded.
- R10: Clearing RUN and then setting it again reloads the full period, whatever count was left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one write per asserted cycle |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sys_rst_req | output | 1 | One-cycle system reset request |
| loc_rst_req | output | 1 | One-cycle local reset request |
| board_fail | output | 1 | Board failure indication, level |

## Verification
The hardest case to reach from the ports is a kick that lands on the same clock edge where the counter would step from one to zero. Only an exact cycle offset from the enabling write brings it about. The bench therefore sweeps the kick offset over every cycle of a short period, including the final one, and checks when expiry appears for each offset. A second sweep covers all eight settings of ARM, SYSSEL and FAILEN. For each setting it checks the one-cycle reset pulses and the level of the fail output.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Bit positions inside the 32-bit control word
  localparam int RUN_BIT     = 16;
  localparam int ARM_BIT     = 17;
  localparam int SYSSEL_BIT  = 18;
  localparam int FAILEN_BIT  = 19;
  localparam int EXPIRED_BIT = 20;
  localparam int KICK_BIT    = 21;
  localparam int ACK_BIT     = 22;

  typedef struct packed {
    logic fail_en;
    logic sys_sel;
    logic rst_arm;
    logic run;
  } wdog_cfg_t;

  localparam wdog_cfg_t CFG_RESET = '{fail_en: 1'b0, sys_sel: 1'b0, rst_arm: 1'b1, run: 1'b0};
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int TIMEOUT_TICKS = 1000,
  localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic load,
  output logic expire
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TIMEOUT_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    expire = 1'b0;
    if (load) begin
      cnt_d  = RELOAD;
      cnt_ce = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_ce = 1'b1;
      expire = (cnt_q == CNT_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == RELOAD));

  // R9
  rest_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && !load) |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        expire,
  output logic [31:0] rd_data,
  output wdog_cfg_t   cfg,
  output logic        expired,
  output logic        load
);
  wdog_cfg_t cfg_q, cfg_d;
  logic      cfg_ce;
  logic      expired_q, expired_d;
  logic      ack;
  logic      unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[31:23], wr_data[EXPIRED_BIT], wr_data[15:0]};

  always_comb begin
    cfg_ce = wr_en;
    cfg_d  = '{fail_en: wr_data[FAILEN_BIT], sys_sel: wr_data[SYSSEL_BIT],
               rst_arm: wr_data[ARM_BIT],   run:     wr_data[RUN_BIT]};
    ack    = wr_en && wr_data[ACK_BIT];
    load   = wr_en && (wr_data[KICK_BIT] || (wr_data[RUN_BIT] && !cfg_q.run));
    if (expire)   expired_d = 1'b1;
    else if (ack) expired_d = 1'b0;
    else          expired_d = expired_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= CFG_RESET;
      expired_q <= 1'b0;
    end else begin
      if (cfg_ce) cfg_q <= cfg_d;
      expired_q <= expired_d;
    end
  end

  always_comb begin
    rd_data              = '0;
    rd_data[RUN_BIT]     = cfg_q.run;
    rd_data[ARM_BIT]     = cfg_q.rst_arm;
    rd_data[SYSSEL_BIT]  = cfg_q.sys_sel;
    rd_data[FAILEN_BIT]  = cfg_q.fail_en;
    rd_data[EXPIRED_BIT] = expired_q;
  end

  assign cfg     = cfg_q;
  assign expired = expired_q;

  // R5
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && !(wr_en && wr_data[ACK_BIT])) |=> expired_q);

  // R2
  idle_no_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.run |=> !$rose(expired_q));
endmodule

// File: rtl/wdog_reset_route.sv
module wdog_reset_route
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      expire,
  input  wdog_cfg_t cfg,
  input  logic      expired,
  output logic      sys_rst_req,
  output logic      loc_rst_req,
  output logic      board_fail
);
  logic sys_q, sys_d;
  logic loc_q, loc_d;
  logic unused_cfg;

  assign unused_cfg = cfg.run;

  always_comb begin
    loc_d = expire && cfg.rst_arm;
    sys_d = expire && cfg.rst_arm && cfg.sys_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q <= 1'b0;
      loc_q <= 1'b0;
    end else begin
      sys_q <= sys_d;
      loc_q <= loc_d;
    end
  end

  assign sys_rst_req = sys_q;
  assign loc_rst_req = loc_q;
  assign board_fail  = expired && cfg.fail_en;

  // R7
  sys_implies_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> loc_rst_req);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_rst_req |=> !loc_rst_req);

  // R7
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.rst_arm |=> !loc_rst_req);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        sys_rst_req,
  output logic        loc_rst_req,
  output logic        board_fail
);
  logic      srst_n;
  logic      expire;
  logic      load;
  logic      expired;
  wdog_cfg_t cfg;

  wdog_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  wdog_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (reg_wr),
    .wr_data (reg_wdata),
    .expire  (expire),
    .rd_data (reg_rdata),
    .cfg     (cfg),
    .expired (expired),
    .load    (load)
  );

  wdog_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
    .clk    (clk),
    .rst_n  (srst_n),
    .run    (cfg.run),
    .load   (load),
    .expire (expire)
  );

  wdog_reset_route u_route (
    .clk         (clk),
    .rst_n       (srst_n),
    .expire      (expire),
    .cfg         (cfg),
    .expired     (expired),
    .sys_rst_req (sys_rst_req),
    .loc_rst_req (loc_rst_req),
    .board_fail  (board_fail)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !srst_n |-> (!sys_rst_req && !loc_rst_req && !board_fail));
endmodule

// File: tb/wdog_guard_tb_top.sv
module wdog_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T = 6;

  localparam logic [31:0] RUN    = 32'h0001_0000;
  localparam logic [31:0] ARM    = 32'h0002_0000;
  localparam logic [31:0] SYSSEL = 32'h0004_0000;
  localparam logic [31:0] FAILEN = 32'h0008_0000;
  localparam logic [31:0] EXPD   = 32'h0010_0000;
  localparam logic [31:0] KICK   = 32'h0020_0000;
  localparam logic [31:0] ACK    = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sys_rst_req, loc_rst_req, board_fail;

  int checks = 0;
  int errors = 0;

  wdog_guard #(.TIMEOUT_TICKS(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sys_rst_req(sys_rst_req),
    .loc_rst_req(loc_rst_req), .board_fail(board_fail)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic quiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, {30'd0, sys_rst_req, loc_rst_req}, 32'd0);
    end
  endtask

  function automatic logic [31:0] flag(input logic [31:0] r);
    return (r & EXPD) >> 20;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    // R1 during reset
    chk("R1", reg_rdata, 32'h0002_0000);
    chk("R1", {29'd0, sys_rst_req, loc_rst_req, board_fail}, 32'd0);
    rst_n = 1'b1;
    step(3);
    // R1 after release
    chk("R1", reg_rdata, 32'h0002_0000);
    chk("R1", {29'd0, sys_rst_req, loc_rst_req, board_fail}, 32'd0);

    // Sweep all routing settings: R3, R7, R8, R9, R6
    for (int c = 0; c < 8; c++) begin
      logic rse, sel, bfe;
      logic [31:0] cfg;
      rse = c[0]; sel = c[1]; bfe = c[2];
      cfg = (rse ? ARM : 0) | (sel ? SYSSEL : 0) | (bfe ? FAILEN : 0);
      wr(cfg | ACK);
      wr(cfg | RUN);
      quiet("R7", T - 1);
      chk("R3", flag(reg_rdata), 0);
      step(1);
      chk("R3", flag(reg_rdata), 1);
      chk("R7", {31'd0, loc_rst_req}, {31'd0, rse});
      chk("R7", {31'd0, sys_rst_req}, {31'd0, rse & sel});
      chk("R8", {31'd0, board_fail}, {31'd0, bfe});
      quiet("R9", 2 * T);
      chk("R8", {31'd0, board_fail}, {31'd0, bfe});
      chk("R6", reg_rdata, cfg | RUN | EXPD);
      wr(cfg);
      chk("R8", {31'd0, board_fail}, {31'd0, bfe});
      wr(cfg | ACK);
      chk("R8", {31'd0, board_fail}, 32'd0);
      chk("R5", flag(reg_rdata), 0);
    end

    // Kick offset sweep, including the expiry edge itself: R4
    for (int k = 1; k <= T; k++) begin
      wr(ACK);
      wr(RUN);
      step(k - 1);
      wr(RUN | KICK);
      step(T - 1);
      chk("R4", flag(reg_rdata), 0);
      step(1);
      chk("R4", flag(reg_rdata), 1);
    end
    wr(ACK);

    // R2: disabled, armed, with kicks: never expires
    wr(ARM);
    quiet("R2", 3 * T);
    wr(ARM | KICK);
    quiet("R2", 3 * T);
    chk("R2", flag(reg_rdata), 0);

    // R10: re-enable reloads full period
    wr(RUN);
    step(T - 2);
    wr(32'd0);
    step(2);
    wr(RUN);
    step(T - 1);
    chk("R10", flag(reg_rdata), 0);
    step(1);
    chk("R10", flag(reg_rdata), 1);
    wr(ACK);

    // R5: write to status bit ignored, sticky, ACK clears
    wr(EXPD);
    chk("R5", flag(reg_rdata), 0);
    wr(RUN);
    step(T);
    chk("R5", flag(reg_rdata), 1);
    wr(32'd0);
    chk("R5", flag(reg_rdata), 1);
    step(T);
    chk("R5", flag(reg_rdata), 1);
    wr(ACK);
    chk("R5", flag(reg_rdata), 0);

    // R6: command and unused bits read zero
    wr(32'hFFFF_FFFF);
    chk("R6", reg_rdata, 32'h000F_0000);
    wr(32'd0);
    chk("R6", reg_rdata, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule